// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a serial-peripheral slave that turns framed commands into accesses on a parallel register bus covering 64 locations of 16 bits each. A frame opens when chip select is pulled low and closes when chip select returns high. Command bits arrive MSB first on the data input and are taken on the falling edges of the serial clock. A completed write frame produces a one-cycle write strobe toward the register file, carrying the address and the data. A completed read frame produces a one-cycle read strobe and captures the returned word.

Readback takes two frames. The frame that follows a read shifts out the previous command's header byte and then the captured word. The serial-data output is presented as a data bit plus an output-enable for an external pad. It is enabled only while a frame is open and the enable configuration input is set. A configuration input selects whether the output bit changes on rising or on falling serial-clock edges. A mode input extends the required frame length from 24 to 32 bits. The extra 8 bits are clocked in but not examined.

All serial inputs pass through a synchronizer into the system clock domain. The serial clock must therefore be several times slower than the system clock.

Top module: `spi_reg_slave`

## Requirements
- R1: A write frame (header bit 23 = 0) that completes with the required bit count raises `busWrEn` for exactly one system clock cycle after chip select rises.
- R2: Bits are taken MSB first on serial-clock falling edges. Bit 23 is the direction (0 write, 1 read), bit 22 is ignored, bits 21:16 are the address, and bits 15:0 are the data. These appear on `busAddr` and `busWrData` during the strobe.
- R3: A frame that closes with fewer falling edges than required produces no strobe. It also leaves the readback header and word unchanged.
- R4: Falling edges beyond the required count do not change the command taken from the first bits.
- R5: With `errCheckMode` = 1, the required count is 32. The first 24 bits are the command, and the last 8 bits are accepted without being examined. A 24-bit frame in this mode is dropped.
- R6: A completed read frame (bit 23 = 1) raises `busRdEn` for one cycle and captures `busRdData`. The next frame shifts out, MSB first, bit 23, bit 22 and the address of the previous valid command, followed by 16 data bits, and zeros after that. The data bits are the captured word after a read and zero after a write. After reset, the first frame shifts out all zeros.
- R7: `sdoOe` is 1 only while chip select is low (after synchronization) and `sdoEnable` is 1.
- R8: With `launchOnRise` = 0, `sdoData` holds bit 23 from frame start and advances on each falling edge. With `launchOnRise` = 1, it advances on each rising edge that follows the frame's first falling edge.
- R9: The data field of a read frame causes no register write.
- R10: After reset, no strobe is raised and `sdoOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdoEnable | input | 1 | Allows the serial output to be driven |
| launchOnRise | input | 1 | 1: output changes on rising edges; 0: on falling edges |
| errCheckMode | input | 1 | 1: 32-bit frames; 0: 24-bit frames |
| sdoData | output | 1 | Serial output bit for the pad |
| sdoOe | output | 1 | Pad output enable; high impedance when 0 |
| busWrEn | output | 1 | One-cycle register write strobe |
| busRdEn | output | 1 | One-cycle register read strobe |
| busAddr | output | 6 | Register address of the frame |
| busWrData | output | 16 | Write data |
| busRdData | input | 16 | Read data, valid in the cycle of `busRdEn` |

## Verification
The assertions assume that chip select, the serial clock and the mode inputs change slowly relative to the system clock. They also assume that no serial-clock edge coincides with a chip-select edge after synchronization, and that `launchOnRise` and `errCheckMode` stay constant inside a frame. The stimulus meets these assumptions. It uses a serial half period of four system cycles, holds the data bit for two cycles after each falling edge, and allows several idle cycles around each chip-select transition. Mode inputs change only between frames.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  // strobes from the frame controller to the shift datapath
  typedef struct packed {
    logic load;     // frame opened: reload output shifter
    logic shiftIn;  // take one command bit
    logic launch;   // advance output shifter
    logic commit;   // frame closed with the required bit count
  } spiStrobes_t;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RESET_VAL;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RESET_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BASE_BITS = 24,
  parameter int EXT_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        launchOnRise,
  input  logic        errCheckMode,
  output logic        sdiBit,
  output logic        csActive,
  output spiStrobes_t ctl
);
  localparam int CNT_W = $clog2(EXT_BITS + 1);
  localparam logic [CNT_W-1:0] BASE_CNT = CNT_W'(BASE_BITS);
  localparam logic [CNT_W-1:0] EXT_CNT = CNT_W'(EXT_BITS);

  logic [2:0] syncOut;
  logic csSync, sclkSync;
  logic csPrev, sclkPrev;
  logic frameStart, frameEnd, fallEdge, riseEdge;
  logic [CNT_W-1:0] bitCount, needBits;

  spi_reg_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sclk, sdi}),
    .dout(syncOut)
  );

  assign csSync   = syncOut[2];
  assign sclkSync = syncOut[1];
  assign sdiBit   = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign csActive   = ~csSync;
  assign frameStart = csPrev & ~csSync;
  assign frameEnd   = ~csPrev & csSync;
  assign fallEdge   = csActive & sclkPrev & ~sclkSync;
  assign riseEdge   = csActive & ~sclkPrev & sclkSync;
  assign needBits   = errCheckMode ? EXT_CNT : BASE_CNT;

  // saturating count of falling edges in the open frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (frameStart) begin
      bitCount <= '0;
    end else if (fallEdge && (bitCount < needBits)) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    ctl.load    = frameStart;
    ctl.shiftIn = fallEdge && (bitCount < BASE_CNT);
    ctl.launch  = launchOnRise ? (riseEdge && (bitCount != '0)) : fallEdge;
    ctl.commit  = frameEnd && (bitCount == needBits);
  end
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       ctl,
  input  logic              sdiBit,
  input  logic [DATA_W-1:0] busRdData,
  output logic              sdoData,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int CMD_W = HDR_W + DATA_W;

  logic [CMD_W-1:0]  cmdReg;
  logic [CMD_W-1:0]  sdoShift;
  logic [HDR_W-1:0]  echoHdr;
  logic [DATA_W-1:0] holdData;
  logic              isRead;

  // command shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (ctl.load) begin
      cmdReg <= '0;
    end else if (ctl.shiftIn) begin
      cmdReg <= {cmdReg[CMD_W-2:0], sdiBit};
    end
  end

  assign isRead    = cmdReg[CMD_W-1];
  assign busAddr   = cmdReg[DATA_W +: ADDR_W];
  assign busWrData = cmdReg[DATA_W-1:0];
  assign busWrEn   = ctl.commit & ~isRead;
  assign busRdEn   = ctl.commit & isRead;

  // readback word held for the next frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      echoHdr  <= '0;
      holdData <= '0;
    end else if (ctl.commit) begin
      echoHdr  <= cmdReg[CMD_W-1 -: HDR_W];
      holdData <= isRead ? busRdData : '0;
    end
  end

  // output shifter, MSB first, zero fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoShift <= '0;
    end else if (ctl.load) begin
      sdoShift <= {echoHdr, holdData};
    end else if (ctl.launch) begin
      sdoShift <= {sdoShift[CMD_W-2:0], 1'b0};
    end
  end

  assign sdoData = sdoShift[CMD_W-1];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EXTRA_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sdoEnable,
  input  logic              launchOnRise,
  input  logic              errCheckMode,
  output logic              sdoData,
  output logic              sdoOe,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] busRdData
);
  localparam int BASE_BITS = 2 + ADDR_W + DATA_W;
  localparam int EXT_BITS = BASE_BITS + EXTRA_BITS;

  spiStrobes_t ctl;
  logic sdiBit;
  logic csActive;

  spi_reg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .BASE_BITS(BASE_BITS),
    .EXT_BITS(EXT_BITS)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .csN         (csN),
    .sclk        (sclk),
    .sdi         (sdi),
    .launchOnRise(launchOnRise),
    .errCheckMode(errCheckMode),
    .sdiBit      (sdiBit),
    .csActive    (csActive),
    .ctl         (ctl)
  );

  spi_reg_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sdiBit   (sdiBit),
    .busRdData(busRdData),
    .sdoData  (sdoData),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .busWrData(busWrData)
  );

  assign sdoOe = sdoEnable & csActive;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic        sdoOe,
  input logic        sdoEnable,
  input spiStrobes_t ctl
);
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busWrEn, busRdEn}));

  assert_write_single_cycle_R1: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> !busWrEn);

  assert_read_single_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> !busRdEn);

  assert_released_at_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn || busRdEn) |-> !sdoOe);

  assert_launch_inside_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.launch && sdoEnable) |-> sdoOe);
endmodule

bind spi_reg_slave spi_reg_slave_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busRdEn  (busRdEn),
  .sdoOe    (sdoOe),
  .sdoEnable(sdoEnable),
  .ctl      (ctl)
);

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4 * CLK_PERIOD;
  localparam int NVEC = 11;
  // {errCheckMode, launchOnRise, bit count, bits sent MSB first from bit 31}
  localparam logic [39:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 6'd24, 32'h05123400},  // R1 R2 write 05 = 1234
    {1'b0, 1'b0, 6'd24, 32'h85000000},  // R6 read 05
    {1'b0, 1'b0, 6'd24, 32'hBF000000},  // R6 read 3F
    {1'b0, 1'b0, 6'd28, 32'h7FBEEFF0},  // R4 write 3F, bit22 set, extra bits
    {1'b0, 1'b0, 6'd20, 32'h05FFFF00},  // R3 short write
    {1'b0, 1'b1, 6'd24, 32'hBF000000},  // R8 read 3F, rising launch
    {1'b1, 1'b1, 6'd32, 32'h105A5AC3},  // R5 write 10 in 32-bit mode
    {1'b1, 1'b0, 6'd24, 32'h90000000},  // R5 short in 32-bit mode
    {1'b1, 1'b0, 6'd32, 32'h900000FF},  // R5 read 10
    {1'b0, 1'b0, 6'd24, 32'h85FFFF00},  // R9 read with data field
    {1'b0, 1'b1, 6'd24, 32'h85000000}   // R9 confirm 05 untouched
  };

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdi, sdoEnable, launchOnRise, errCheckMode;
  logic sdoData, sdoOe, busWrEn, busRdEn;
  logic [5:0] busAddr;
  logic [15:0] busWrData, busRdData;

  logic [15:0] mem [64];
  int wrCnt = 0, rdCnt = 0;
  logic [5:0] lastWrAddr;
  logic [15:0] lastWrData;
  int checks = 0, fails = 0;
  logic oeSeen;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_reg_slave uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdoEnable(sdoEnable), .launchOnRise(launchOnRise), .errCheckMode(errCheckMode),
    .sdoData(sdoData), .sdoOe(sdoOe), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  assign busRdData = mem[busAddr];

  initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

  always @(posedge clk) begin
    if (busWrEn) begin
      mem[busAddr] <= busWrData;
      wrCnt <= wrCnt + 1;
      lastWrAddr <= busAddr;
      lastWrData <= busWrData;
    end
    if (busRdEn) rdCnt <= rdCnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runFrame(input logic [31:0] bits, input int n, input logic rise,
                          output logic [31:0] got);
    got = '0;
    oeSeen = 1'b0;
    csN = 1'b0;
    #(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = bits[31-i];
      #(HALF);
      if (i == 0) oeSeen = sdoOe;
      if (!rise) got[31-i] = sdoData;
      sclk = 1'b1;
      #(HALF);
      if (rise) got[31-i] = sdoData;
      sclk = 1'b0;
      #(2 * CLK_PERIOD);
    end
    #(HALF);
    csN = 1'b1;
    #(8 * CLK_PERIOD);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] modelMem [64];
    logic [23:0] expEcho;
    logic [31:0] got, mask;
    int wr0, rd0, need, n;
    logic err, rise, valid, rw;
    logic [31:0] bits;

    for (int i = 0; i < 64; i++) modelMem[i] = 16'h0000;
    expEcho = '0;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0;
    sdoEnable = 1'b1; launchOnRise = 1'b0; errCheckMode = 1'b0;
    #3;
    #(5 * CLK_PERIOD);
    // R10: reset state
    check("R10 sdoOe in reset", {31'b0, sdoOe}, 32'd0);
    check("R10 strobes in reset", {30'b0, busWrEn, busRdEn}, 32'd0);
    rstN = 1'b1;
    #(5 * CLK_PERIOD);
    check("R10 no strobe after reset", wrCnt + rdCnt, 32'd0);
    check("R7 sdoOe idle with chip select high", {31'b0, sdoOe}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      err = VECS[v][39];
      rise = VECS[v][38];
      n = int'(VECS[v][37:32]);
      bits = VECS[v][31:0];
      errCheckMode = err;
      launchOnRise = rise;
      #(2 * CLK_PERIOD);
      wr0 = wrCnt;
      rd0 = rdCnt;
      runFrame(bits, n, rise, got);
      mask = ~(32'hFFFFFFFF >> n);
      // R6 R8 echo of previous valid command, R3 dropped frames keep it
      check($sformatf("R6 R8 readback vector %0d", v), got & mask, {expEcho, 8'h00} & mask);
      if (v == 0) check("R7 sdoOe inside frame", {31'b0, oeSeen}, 32'd1);
      need = err ? 32 : 24;
      valid = (n >= need);
      rw = bits[31];
      check($sformatf("R1 R3 R5 R9 write strobes vector %0d", v), wrCnt - wr0,
            (valid && !rw) ? 32'd1 : 32'd0);
      check($sformatf("R3 R5 R6 read strobes vector %0d", v), rdCnt - rd0,
            (valid && rw) ? 32'd1 : 32'd0);
      if (valid && !rw) begin
        // R2 R4 field positions
        check($sformatf("R2 R4 write address vector %0d", v), {26'b0, lastWrAddr}, {26'b0, bits[29:24]});
        check($sformatf("R2 R4 write data vector %0d", v), {16'b0, lastWrData}, {16'b0, bits[23:8]});
        modelMem[bits[29:24]] = bits[23:8];
      end
      if (valid) expEcho = {bits[31:24], rw ? modelMem[bits[29:24]] : 16'h0000};
    end

    // R7: output disabled by configuration during a frame
    sdoEnable = 1'b0;
    errCheckMode = 1'b0;
    launchOnRise = 1'b0;
    #(2 * CLK_PERIOD);
    runFrame(32'h85000000, 24, 1'b0, got);
    check("R7 sdoOe with enable clear", {31'b0, oeSeen}, 32'd0);
    sdoEnable = 1'b1;
    #(2 * CLK_PERIOD);
    // R9: register 05 still holds the value written in vector 0
    check("R9 register 05 untouched", {16'b0, mem[5]}, 32'h00001234);
    check("R7 sdoOe after frame", {31'b0, sdoOe}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule